// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is a hardware sequencer that configures a target FPGA through an 8-bit parallel slave port, and that can also read configuration bytes back from the same port. A host starts a run with a one-cycle `start` pulse. At that pulse the block captures the direction (`rb_mode`), the byte count (`xfer_len`), the busy-check enable (`busy_chk`) and the half-phase divider (`half_div`). Load bytes arrive on a valid/ready stream. Readback bytes leave on a valid-only stream.

A load runs in this order. The program pin is pulsed low. The block waits for the target's init pin to go low and then high again while the target's busy pin is low. It then asserts write, then chip select, and sends one byte per configuration-clock rising edge. When busy checking is on, the block re-clocks a byte for as long as the target reports busy. After the last byte it releases chip select, then write, and keeps clocking until the done pin rises. A readback asserts chip select with write released and captures one byte after each rising edge. It then releases chip select and gives one final clock. Every wait on the target is bounded by a cycle timeout. A timeout ends the run with a failure pulse, an abort pulse and a reason code, and all control pins return to their inactive levels.

The sequencer states are as follows. `ST_IDLE` goes to `ST_PROG_LO` on `start` (load), or to `ST_RB_SEL` (readback). `ST_PROG_LO` goes to `ST_PROG_WAIT` once the phase has ended and init is seen low. `ST_PROG_WAIT` goes to `ST_WR_ON` when init is high and busy is low. `ST_WR_ON` goes to `ST_CS_ON`. `ST_CS_ON` goes to `ST_FETCH`, or to `ST_CS_OFF` when the count is zero. `ST_FETCH` goes to `ST_DAT_LO` on a stream handshake. `ST_DAT_LO` goes to `ST_DAT_HI`. `ST_DAT_HI` goes to `ST_BSY_LO` (busy seen with checking on), to `ST_FETCH`, or to `ST_CS_OFF`. `ST_BSY_LO` and `ST_BSY_HI` alternate until busy clears. `ST_CS_OFF` goes to `ST_WR_OFF`. `ST_WR_OFF` goes to `ST_PASS`, or to `ST_DN_LO`. `ST_DN_LO` and `ST_DN_HI` alternate until done is high. On the readback side, `ST_RB_SEL` goes to `ST_RB_LO`, `ST_RB_LO` to `ST_RB_HI`, and `ST_RB_HI` back to `ST_RB_LO` until the last byte. `ST_RB_HI` then goes to `ST_RB_REL`, followed by `ST_RB_FLO`, `ST_RB_FHI` and `ST_PASS`. A timeout in `ST_PROG_LO`, `ST_PROG_WAIT`, `ST_BSY_*` or `ST_DN_*` goes to `ST_FAIL`. `ST_PASS` and `ST_FAIL` both return to `ST_IDLE` after one cycle.

Top module: `pcl_loader`

## Requirements
- R1: After reset and while idle, `cfg_prog_n`, `cfg_sel_n` and `cfg_wr_n` are high, `cfg_clk` is high, `cfg_doe` is low and `busy` is low.
- R2: Every phase driven by the sequencer (each low or high half of `cfg_clk`, and each control step) lasts `half_div`+1 clock cycles.
- R3: A load first drives `cfg_prog_n` low, then releases it after init has been seen low. `cfg_wr_n` is never asserted while `cfg_prog_n` is low or while `cfg_init_n` is low.
- R4: If init does not complete within `TIMEOUT_CYC` cycles, `fail` and `abort` pulse together for one cycle with `reason` = 1. The next cycle is idle, with program, select and write all high.
- R5: Write is asserted at least one cycle before select, and `cfg_clk` is high when select falls.
- R6: Load bytes appear on `cfg_dout` in stream order, one per `cfg_clk` rising edge, exactly `xfer_len` of them. `s_ready` is only high while `cfg_clk` is high. A count of zero produces no data edges.
- R7: With `busy_chk` set, a byte after whose edge busy is high is re-clocked with the same value until busy clears. This produces exactly one extra rising edge per busy-high rising edge.
- R8: With `busy_chk` clear, the busy pin has no effect on the data phase: no byte is re-clocked.
- R9: A busy wait longer than `TIMEOUT_CYC` cycles ends with `fail` and `abort` and `reason` = 2.
- R10: At the end of a load, select is released at least one cycle before write.
- R11: After write is released, `cfg_clk` toggles until done is high (no extra edge if done is already high). `ok` then pulses for one cycle and `reason` reads 0.
- R12: A done wait longer than `TIMEOUT_CYC` cycles ends with `fail` and `abort` and `reason` = 3.
- R13: Readback holds write high and select low, and issues `xfer_len` rising edges. It presents `cfg_din` on `m_data` with an `m_valid` pulse after each edge, then releases select and gives one final clock edge.
- R14: `cfg_doe` is high only during a load while both select and write are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle run request, taken only when idle |
| rb_mode | input | 1 | 1 = readback, 0 = load (sampled at start) |
| xfer_len | input | CNT_W | Number of bytes to move (sampled at start) |
| busy_chk | input | 1 | Enables re-clocking on target busy (sampled at start) |
| half_div | input | DIV_W | Phase length minus one, in clock cycles (sampled at start) |
| s_data | input | DATA_W | Load byte stream data |
| s_valid | input | 1 | Load byte stream valid |
| s_ready | output | 1 | Load byte stream ready |
| m_data | output | DATA_W | Readback byte |
| m_valid | output | 1 | Readback byte valid, one cycle |
| cfg_prog_n | output | 1 | Target program pin, active low |
| cfg_sel_n | output | 1 | Target chip select, active low |
| cfg_wr_n | output | 1 | Target write enable, active low |
| cfg_clk | output | 1 | Target configuration clock |
| cfg_dout | output | DATA_W | Data driven toward the target |
| cfg_doe | output | 1 | Output enable for the data bus |
| cfg_din | input | DATA_W | Data read from the target |
| cfg_init_n | input | 1 | Target init pin, low while initialising |
| cfg_busy | input | 1 | Target busy pin |
| cfg_done | input | 1 | Target done pin |
| busy | output | 1 | Run in progress |
| ok | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| abort | output | 1 | One-cycle abort pulse on timeout |
| reason | output | 2 | Outcome code of the last run: 0 none, 1 init, 2 busy, 3 done |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 400, `CNT_W` = 8 and `DIV_W` = 4. The short timeout makes all three timeout exits (init, busy and done) reachable within a few hundred cycles each. The small count width keeps byte sequences short. Runs use `half_div` = 3, where the two-flop synchronizer lag fits inside one phase, so busy re-clock edges and post-load done edges can be counted exactly. Runs also use `half_div` = 0, where each clock half is a single cycle and the phase-length rule is tested at its lower bound.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PROG_LO,
        ST_PROG_WAIT,
        ST_WR_ON,
        ST_CS_ON,
        ST_FETCH,
        ST_DAT_LO,
        ST_DAT_HI,
        ST_BSY_LO,
        ST_BSY_HI,
        ST_CS_OFF,
        ST_WR_OFF,
        ST_DN_LO,
        ST_DN_HI,
        ST_RB_SEL,
        ST_RB_LO,
        ST_RB_HI,
        ST_RB_REL,
        ST_RB_FLO,
        ST_RB_FHI,
        ST_PASS,
        ST_FAIL
    } pcl_state_e;

    typedef enum logic [1:0] {
        RSN_NONE = 2'd0,
        RSN_INIT = 2'd1,
        RSN_BUSY = 2'd2,
        RSN_DONE = 2'd3
    } pcl_reason_e;

endpackage

// File: rtl/pcl_sync.sv
module pcl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pcl_phase.sv
module pcl_phase #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcl_wait_timer.sv
module pcl_wait_timer #(
    parameter int LIMIT = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    assign expired = (cnt == TW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4
    idle_timer_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !expired);
endmodule

// File: rtl/pcl_loader.sv
module pcl_loader
    import pcl_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int DIV_W       = 8,
    parameter int TIMEOUT_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rb_mode,
    input  logic [CNT_W-1:0]  xfer_len,
    input  logic              busy_chk,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    output logic              cfg_prog_n,
    output logic              cfg_sel_n,
    output logic              cfg_wr_n,
    output logic              cfg_clk,
    output logic [DATA_W-1:0] cfg_dout,
    output logic              cfg_doe,
    input  logic [DATA_W-1:0] cfg_din,
    input  logic              cfg_init_n,
    input  logic              cfg_busy,
    input  logic              cfg_done,
    output logic              busy,
    output logic              ok,
    output logic              fail,
    output logic              abort,
    output logic [1:0]        reason
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    pcl_state_e        st_q, st_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] dat_q;
    logic              rb_q, bchk_q;
    pcl_reason_e       reason_q;

    logic [2:0] pins_s;
    logic       init_s, busy_s, done_s;
    logic       tick, expired;
    logic       grp_init, grp_bsy, grp_dn;

    pcl_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cfg_init_n, cfg_busy, cfg_done}),
        .q     (pins_s)
    );
    assign init_s = pins_s[2];
    assign busy_s = pins_s[1];
    assign done_s = pins_s[0];

    pcl_phase #(.DIV_W(DIV_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st_n != st_q),
        .div     (div_q),
        .tick    (tick)
    );

    assign grp_init = (st_q == ST_PROG_LO) || (st_q == ST_PROG_WAIT);
    assign grp_bsy  = (st_q == ST_BSY_LO)  || (st_q == ST_BSY_HI);
    assign grp_dn   = (st_q == ST_DN_LO)   || (st_q == ST_DN_HI);

    pcl_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (grp_init || grp_bsy || grp_dn),
        .expired (expired)
    );

    // Next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:      if (start) st_n = rb_mode ? ST_RB_SEL : ST_PROG_LO;
            ST_PROG_LO: begin
                if (tick && !init_s)    st_n = ST_PROG_WAIT;
                else if (expired)       st_n = ST_FAIL;
            end
            ST_PROG_WAIT: begin
                if (init_s && !busy_s)  st_n = ST_WR_ON;
                else if (expired)       st_n = ST_FAIL;
            end
            ST_WR_ON:     if (tick) st_n = ST_CS_ON;
            ST_CS_ON:     if (tick) st_n = (cnt_q == '0) ? ST_CS_OFF : ST_FETCH;
            ST_FETCH:     if (s_valid) st_n = ST_DAT_LO;
            ST_DAT_LO:    if (tick) st_n = ST_DAT_HI;
            ST_DAT_HI: begin
                if (tick) begin
                    if (bchk_q && busy_s)  st_n = ST_BSY_LO;
                    else if (cnt_q == ONE) st_n = ST_CS_OFF;
                    else                   st_n = ST_FETCH;
                end
            end
            ST_BSY_LO: begin
                if (expired)    st_n = ST_FAIL;
                else if (tick)  st_n = ST_BSY_HI;
            end
            ST_BSY_HI: begin
                if (expired)             st_n = ST_FAIL;
                else if (tick) begin
                    if (busy_s)            st_n = ST_BSY_LO;
                    else if (cnt_q == '0)  st_n = ST_CS_OFF;
                    else                   st_n = ST_FETCH;
                end
            end
            ST_CS_OFF:    if (tick) st_n = ST_WR_OFF;
            ST_WR_OFF:    if (tick) st_n = done_s ? ST_PASS : ST_DN_LO;
            ST_DN_LO: begin
                if (expired)    st_n = ST_FAIL;
                else if (tick)  st_n = ST_DN_HI;
            end
            ST_DN_HI: begin
                if (expired)    st_n = ST_FAIL;
                else if (tick)  st_n = done_s ? ST_PASS : ST_DN_LO;
            end
            ST_RB_SEL:    if (tick) st_n = (cnt_q == '0) ? ST_RB_REL : ST_RB_LO;
            ST_RB_LO:     if (tick) st_n = ST_RB_HI;
            ST_RB_HI:     if (tick) st_n = (cnt_q == ONE) ? ST_RB_REL : ST_RB_LO;
            ST_RB_REL:    if (tick) st_n = ST_RB_FLO;
            ST_RB_FLO:    if (tick) st_n = ST_RB_FHI;
            ST_RB_FHI:    if (tick) st_n = ST_PASS;
            ST_PASS:      st_n = ST_IDLE;
            ST_FAIL:      st_n = ST_IDLE;
            default:      st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Run context, byte count and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            div_q    <= '0;
            dat_q    <= '0;
            rb_q     <= 1'b0;
            bchk_q   <= 1'b0;
            reason_q <= RSN_NONE;
            m_data   <= '0;
            m_valid  <= 1'b0;
        end else begin
            m_valid <= 1'b0;
            if (st_q == ST_IDLE && start) begin
                rb_q     <= rb_mode;
                bchk_q   <= busy_chk;
                cnt_q    <= xfer_len;
                div_q    <= half_div;
                reason_q <= RSN_NONE;
            end
            if (st_q == ST_FETCH && s_valid) dat_q <= s_data;
            if (st_q == ST_DAT_HI && tick)   cnt_q <= cnt_q - ONE;
            if (st_q == ST_RB_HI && tick) begin
                m_data  <= cfg_din;
                m_valid <= 1'b1;
                cnt_q   <= cnt_q - ONE;
            end
            if (st_n == ST_FAIL && st_q != ST_FAIL) begin
                if (grp_init)     reason_q <= RSN_INIT;
                else if (grp_bsy) reason_q <= RSN_BUSY;
                else              reason_q <= RSN_DONE;
            end
        end
    end

    // Output decode
    always_comb begin
        cfg_prog_n = 1'b1;
        cfg_sel_n  = 1'b1;
        cfg_wr_n   = 1'b1;
        cfg_clk    = 1'b1;
        cfg_doe    = 1'b0;
        s_ready    = 1'b0;
        unique case (st_q)
            ST_PROG_LO: cfg_prog_n = 1'b0;
            ST_WR_ON:   cfg_wr_n   = 1'b0;
            ST_CS_ON, ST_DAT_HI, ST_BSY_HI: begin
                cfg_wr_n  = 1'b0;
                cfg_sel_n = 1'b0;
                cfg_doe   = 1'b1;
            end
            ST_FETCH: begin
                cfg_wr_n  = 1'b0;
                cfg_sel_n = 1'b0;
                cfg_doe   = 1'b1;
                s_ready   = 1'b1;
            end
            ST_DAT_LO, ST_BSY_LO: begin
                cfg_wr_n  = 1'b0;
                cfg_sel_n = 1'b0;
                cfg_doe   = 1'b1;
                cfg_clk   = 1'b0;
            end
            ST_CS_OFF:  cfg_wr_n = 1'b0;
            ST_DN_LO:   cfg_clk  = 1'b0;
            ST_RB_SEL, ST_RB_HI: cfg_sel_n = 1'b0;
            ST_RB_LO: begin
                cfg_sel_n = 1'b0;
                cfg_clk   = 1'b0;
            end
            ST_RB_FLO:  cfg_clk = 1'b0;
            default: ;
        endcase
    end

    assign cfg_dout = dat_q;
    assign busy     = (st_q != ST_IDLE);
    assign ok       = (st_q == ST_PASS);
    assign fail     = (st_q == ST_FAIL);
    assign abort    = (st_q == ST_FAIL);
    assign reason   = reason_q;

    // R5
    wr_before_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_sel_n) && !rb_q) |-> ($past(!cfg_wr_n) && cfg_clk));

    // R10
    sel_before_wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr_n) |-> cfg_sel_n);

    // R14
    doe_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_doe |-> (!cfg_sel_n && !cfg_wr_n && !rb_q));

    // R6
    ready_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> cfg_clk);

    // R6
    data_stable_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_doe && $rose(cfg_clk)) |-> $stable(cfg_dout));

    // R4
    abort_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (cfg_prog_n && cfg_sel_n && cfg_wr_n && !busy));

    // R13
    rb_capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (rb_q && cfg_wr_n));
endmodule

// File: tb/tb_pcl_loader.sv
`timescale 1ns/1ps
module tb_pcl_loader;
    localparam int DW = 8, CW = 8, VW = 4, TMO = 400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, rb_mode = 1'b0, busy_chk = 1'b0;
    logic [CW-1:0] xfer_len = '0;
    logic [VW-1:0] half_div = '0;
    logic [DW-1:0] s_data = '0, m_data, cfg_dout, cfg_din = '0;
    logic s_valid = 1'b0, s_ready, m_valid;
    logic cfg_prog_n, cfg_sel_n, cfg_wr_n, cfg_clk, cfg_doe;
    logic cfg_init_n = 1'b1, cfg_busy = 1'b0, cfg_done = 1'b0;
    logic busy, ok, fail, abort;
    logic [1:0] reason;

    pcl_loader #(.DATA_W(DW), .CNT_W(CW), .DIV_W(VW), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rb_mode(rb_mode),
        .xfer_len(xfer_len), .busy_chk(busy_chk), .half_div(half_div),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .m_data(m_data), .m_valid(m_valid),
        .cfg_prog_n(cfg_prog_n), .cfg_sel_n(cfg_sel_n), .cfg_wr_n(cfg_wr_n),
        .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .cfg_doe(cfg_doe),
        .cfg_din(cfg_din), .cfg_init_n(cfg_init_n), .cfg_busy(cfg_busy),
        .cfg_done(cfg_done), .busy(busy), .ok(ok), .fail(fail),
        .abort(abort), .reason(reason));

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard and test configuration
    logic [7:0] exp_q[$];
    logic [7:0] src[64];
    int feed_n = 0, feed_k = 0;
    int m_idx = 0;
    bit rb_test = 0, hold_init = 0, bchk_tb = 0, mon_on = 0;
    int busy_at = -1, busy_len = 0, done_after = 0, init_dly = 0;
    int data_rises = 0, post_rises = 0, rb_rises = 0, reclk = 0, bsy_left = 0, acc = 0;
    int lo_run = 0, lo_min = 0, lo_max = 0, doe_cnt = 0;
    int err3 = 0, err5 = 0, err6 = 0, err7 = 0, err10 = 0, err14 = 0, err13 = 0;
    bit wr_seen = 0, prev_clk = 1, prev_sel = 1, prev_wr = 1;
    logic [7:0] last_byte = '0;

    function automatic logic [7:0] rb_pat(input int i);
        return 8'hA5 ^ 8'(i * 29);
    endfunction

    // stream driver
    always @(negedge clk) begin
        if (feed_k < feed_n) begin
            s_valid <= 1'b1;
            s_data  <= src[feed_k];
            if (s_ready) feed_k = feed_k + 1;
        end else begin
            s_valid <= 1'b0;
        end
    end

    // target model and monitor
    always @(negedge clk) begin
        if (mon_on) begin
            bit rise;
            rise = cfg_clk && !prev_clk;
            if (!cfg_prog_n) begin
                cfg_init_n = 1'b0; cfg_done = 1'b0; cfg_busy = 1'b0; init_dly = 0;
            end else if (!cfg_init_n && !hold_init) begin
                init_dly++;
                if (init_dly >= 6) cfg_init_n = 1'b1;
            end
            if (!cfg_wr_n && (!cfg_prog_n || !cfg_init_n)) err3++;
            if (!cfg_wr_n) wr_seen = 1;
            if (s_ready && !cfg_clk) err6++;
            if (cfg_doe) begin
                doe_cnt++;
                if (cfg_sel_n || cfg_wr_n || rb_test) err14++;
            end
            if (prev_sel && !cfg_sel_n && !rb_test && (prev_wr || !cfg_clk)) err5++;
            if (!prev_wr && cfg_wr_n && !prev_sel) err10++;
            if (rb_test && !cfg_wr_n) err13++;
            if (!cfg_clk) lo_run++;
            if (rise) begin
                if (!cfg_sel_n && !cfg_wr_n) begin
                    if (lo_run < lo_min) lo_min = lo_run;
                    if (lo_run > lo_max) lo_max = lo_run;
                    if (bchk_tb && bsy_left != 0) begin
                        reclk++;
                        chk_eq("R7 re-clocked byte value", cfg_dout, last_byte);
                        if (bsy_left > 0) begin
                            bsy_left--;
                            if (bsy_left == 0) cfg_busy = 1'b0;
                        end
                    end else begin
                        data_rises++; acc++;
                        last_byte = cfg_dout;
                        if (exp_q.size() == 0) chk_eq("R6 unexpected byte edge", 1, 0);
                        else chk_eq("R6 byte order", cfg_dout, exp_q.pop_front());
                        if (acc == busy_at) begin
                            cfg_busy = 1'b1;
                            bsy_left = bchk_tb ? busy_len : 0;
                        end
                    end
                end else if (!cfg_sel_n && cfg_wr_n) begin
                    cfg_din = rb_pat(rb_rises);
                    rb_rises++;
                end else if (cfg_sel_n && cfg_wr_n) begin
                    post_rises++;
                end
            end
            if (cfg_clk) lo_run = 0;
            if (wr_seen && cfg_sel_n && cfg_wr_n && cfg_prog_n && post_rises >= done_after)
                cfg_done = 1'b1;
            if (m_valid) begin
                chk_eq("R13 readback byte", m_data, rb_pat(m_idx));
                m_idx++;
            end
            prev_clk = cfg_clk; prev_sel = cfg_sel_n; prev_wr = cfg_wr_n;
        end
    end

    task automatic reset_model();
        exp_q.delete();
        feed_n = 0; feed_k = 0; m_idx = 0; acc = 0;
        data_rises = 0; post_rises = 0; rb_rises = 0; reclk = 0; bsy_left = 0;
        lo_run = 0; lo_min = 1000; lo_max = 0; doe_cnt = 0;
        err3 = 0; err5 = 0; err6 = 0; err7 = 0; err10 = 0; err14 = 0; err13 = 0;
        wr_seen = 0; cfg_busy = 1'b0; cfg_done = 1'b0;
    endtask

    // driver: pushes expected bytes, then starts a run and waits for its end
    task automatic run(input bit rb, input int n, input int div, input bit chk,
                       output bit got_ok, output bit got_fail, output bit got_abort,
                       output int rsn);
        reset_model();
        rb_test = rb; bchk_tb = chk;
        if (!rb) begin
            for (int k = 0; k < n; k++) begin
                src[k] = 8'(n * 37 + k * 53 + div);
                exp_q.push_back(src[k]);
            end
            feed_n = n;
        end
        mon_on = 1;
        @(negedge clk);
        start = 1'b1; rb_mode = rb; xfer_len = CW'(n); half_div = VW'(div); busy_chk = chk;
        @(negedge clk);
        start = 1'b0;
        got_ok = 0; got_fail = 0; got_abort = 0; rsn = -1;
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (ok || fail) begin
                got_ok = ok; got_fail = fail; got_abort = abort; rsn = reason;
                break;
            end
        end
        @(negedge clk);
        chk_eq("R4 idle pins after run", {cfg_prog_n, cfg_sel_n, cfg_wr_n, busy, ok, fail}, 6'b111000);
        feed_n = 0; feed_k = 0;
        mon_on = 0; hold_init = 0; busy_at = -1; busy_len = 0;
        cfg_init_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit g_ok, g_fail, g_ab;
        int rs;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 reset pins", {cfg_prog_n, cfg_sel_n, cfg_wr_n, cfg_clk, cfg_doe, busy}, 6'b111100);

        // T1: plain load, done after 3 edges
        done_after = 3;
        run(0, 5, 3, 1, g_ok, g_fail, g_ab, rs);
        chk_eq("R11 load success", g_ok, 1);
        chk_eq("R11 reason after success", rs, 0);
        chk_eq("R6 data edge count", data_rises, 5);
        chk_eq("R6 all bytes delivered", exp_q.size(), 0);
        chk_eq("R11 post-load edges", post_rises, 3);
        chk_eq("R2 low phase min", lo_min, 4);
        chk_eq("R2 low phase max", lo_max, 4);
        chk_eq("R3 write gating", err3, 0);
        chk_eq("R5 write before select", err5, 0);
        chk_eq("R10 select released first", err10, 0);
        chk_eq("R6 ready only clock high", err6, 0);
        chk_eq("R14 output enable gating", err14, 0);
        chk_eq("R7 no re-clock without busy", reclk, 0);

        // T2: fastest divider
        done_after = 1;
        run(0, 4, 0, 1, g_ok, g_fail, g_ab, rs);
        chk_eq("R2 div0 success", g_ok, 1);
        chk_eq("R2 div0 low phase min", lo_min, 1);
        chk_eq("R2 div0 low phase max", lo_max, 1);
        chk_eq("R6 div0 edge count", data_rises, 4);

        // T3: busy re-clock
        done_after = 0; busy_at = 2; busy_len = 3;
        run(0, 6, 3, 1, g_ok, g_fail, g_ab, rs);
        chk_eq("R7 success", g_ok, 1);
        chk_eq("R7 extra edges", reclk, 3);
        chk_eq("R7 data edges", data_rises, 6);
        chk_eq("R11 done already high, no extra edge", post_rises, 0);

        // T4: busy ignored with check disabled
        done_after = 2; busy_at = 1; busy_len = 5;
        run(0, 4, 3, 0, g_ok, g_fail, g_ab, rs);
        chk_eq("R8 success", g_ok, 1);
        chk_eq("R8 no re-clock", reclk, 0);
        chk_eq("R8 data edges", data_rises, 4);
        chk_eq("R8 bytes delivered", exp_q.size(), 0);

        // T5: zero-length load
        done_after = 1;
        run(0, 0, 3, 1, g_ok, g_fail, g_ab, rs);
        chk_eq("R6 zero length success", g_ok, 1);
        chk_eq("R6 zero length edges", data_rises, 0);
        chk_eq("R5 zero length order", err5, 0);
        chk_eq("R10 zero length order", err10, 0);

        // T6: readback
        run(1, 5, 3, 0, g_ok, g_fail, g_ab, rs);
        chk_eq("R13 readback success", g_ok, 1);
        chk_eq("R13 readback edges", rb_rises, 5);
        chk_eq("R13 captured bytes", m_idx, 5);
        chk_eq("R13 final clock", post_rises, 1);
        chk_eq("R13 write held high", err13, 0);
        chk_eq("R14 no enable in readback", doe_cnt, 0);

        // T7: zero-length readback
        run(1, 0, 2, 0, g_ok, g_fail, g_ab, rs);
        chk_eq("R13 empty readback success", g_ok, 1);
        chk_eq("R13 empty readback captures", m_idx, 0);
        chk_eq("R13 empty readback final clock", post_rises, 1);

        // T8: init timeout
        hold_init = 1;
        run(0, 3, 3, 1, g_ok, g_fail, g_ab, rs);
        chk_eq("R4 init timeout fail", g_fail, 1);
        chk_eq("R4 init timeout abort", g_ab, 1);
        chk_eq("R4 init timeout reason", rs, 1);
        chk_eq("R3 no write during init", err3, 0);
        chk_eq("R4 no data sent", data_rises, 0);

        // T9: busy timeout
        done_after = 0; busy_at = 1; busy_len = -1;
        run(0, 4, 3, 1, g_ok, g_fail, g_ab, rs);
        chk_eq("R9 busy timeout fail", g_fail, 1);
        chk_eq("R9 busy timeout abort", g_ab, 1);
        chk_eq("R9 busy timeout reason", rs, 2);

        // T10: done timeout
        done_after = 100000;
        run(0, 2, 3, 1, g_ok, g_fail, g_ab, rs);
        chk_eq("R12 done timeout fail", g_fail, 1);
        chk_eq("R12 done timeout abort", g_ab, 1);
        chk_eq("R12 done timeout reason", rs, 3);
        chk_eq("R12 bytes delivered", data_rises, 2);

        // R1 idle again
        @(negedge clk);
        chk_eq("R1 idle pins at end", {cfg_prog_n, cfg_sel_n, cfg_wr_n, cfg_clk, cfg_doe, busy}, 6'b111100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule